// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block gathers a wide vector of level-sensitive interrupt requests, grouped into banks of 32 lines, and presents one interrupt to a processor. Line n lives in bank n/32 at bit n mod 32. Each line has a mask bit. Software changes mask bits only through two strobe registers per bank. A write to the "set" register masks every line whose data bit is 1. A write to the "clear" register unmasks every line whose data bit is 1. Data bits that are 0 leave their mask bits unchanged.

When the controller is idle and at least one unmasked line is asserted, it latches the lowest-numbered such line. It raises the interrupt output and keeps both the output and the latched number fixed until software writes an acknowledge. A line that is still asserted and unmasked after the acknowledge is presented again.

A software reset masks every line and drops any presented interrupt for a fixed number of cycles. A status bit lets software poll for the end of that reset. The register port is a plain 32-bit bus with a word address, a write enable and combinational read data.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After hardware reset, irq_out is 0, active_id is 0, every mask bit is 1, and the status register (byte 0x14) reads 1 in bit 0. With all lines masked, no level on irq_lines raises irq_out.
- R2: Byte offset 0x00 reads the REVISION parameter in bits 7:0 (major in 7:4, minor in 3:0) and 0 in the upper bits.
- R3: A write to byte 0x8C + 0x20*b sets the mask bit of every line of bank b (b = 0..NBANK-1) whose data bit is 1 and leaves the other mask bits unchanged. A read of 0x88 + 0x20*b or 0x8C + 0x20*b returns bank b's mask word.
- R4: A write to byte 0x88 + 0x20*b clears the mask bit of every line of bank b whose data bit is 1 and leaves the other mask bits unchanged.
- R5: A read of byte 0x98 + 0x20*b returns, for bank b, the current input levels ANDed with the inverted mask bits.
- R6: When irq_out is 0, no software reset is in progress and some unmasked line is high, then at the next clock irq_out becomes 1, and both active_id and the register at byte 0x40 (bits 6:0) hold the lowest such line number.
- R7: While irq_out is 1, it stays 1 and active_id stays unchanged until an acknowledge or a software reset, whatever the lines and the mask bits do.
- R8: A write to byte 0x48 with data bit 0 set while irq_out is 1 drops irq_out at the next clock. If an unmasked line is still high, irq_out rises again one clock later with a freshly chosen lowest line. The same write with bit 0 clear, or while irq_out is 0, has no effect.
- R9: A write to byte 0x10 with data bit 1 set starts a software reset that lasts RST_CYCLES clocks. During it, byte 0x10 reads 1 in bit 1, byte 0x14 reads 0 in bit 0, irq_out and active_id are 0, all mask bits are 1, and mask writes and acknowledges are ignored. Afterwards byte 0x14 bit 0 reads 1 and byte 0x10 bit 1 reads 0.
- R10: A read of any byte offset not named above returns 0, and a write to one changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NBANK*32 | Level interrupt requests, line n at bit n |
| bus_addr | input | AW | Word address (byte offset / 4) |
| bus_wr | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_out | output | 1 | Interrupt to the processor |
| active_id | output | $clog2(NBANK*32) | Number of the presented line |

## Verification
A corrupted mask bit appears at once in the pending and mask readbacks, and it appears within one clock as a wrong choice of presented line. A wrong presentation state shows in irq_out and active_id on the first clock after the event that caused it. An off-by-one in the reset counter changes the status bit in exactly one cycle, so the bench compares every port against its model on every clock rather than only at the end of each scenario.

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int NBANK = 3,
  parameter int RST_CYCLES = 6,
  parameter logic [7:0] REVISION = 8'h21,
  parameter int AW = 8,
  localparam int N = NBANK * 32,
  localparam int ID_W = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    irq_lines,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_out,
  output logic [ID_W-1:0] active_id
);

  localparam int W_REV    = 0;
  localparam int W_CFG    = 4;
  localparam int W_STAT   = 5;
  localparam int W_ACT    = 16;
  localparam int W_CTRL   = 18;
  localparam int W_MCLR0  = 34;
  localparam int W_MSET0  = 35;
  localparam int W_PEND0  = 38;
  localparam int W_STRIDE = 8;
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [N-1:0]    mask;
  logic [N-1:0]    pend;
  logic [CW-1:0]   cnt;
  logic            busy, srst_go, ack, any;
  logic [ID_W-1:0] first_id;

  assign pend    = irq_lines & ~mask;
  assign any     = |pend;
  assign busy    = cnt != '0;
  assign srst_go = bus_wr && bus_addr == AW'(W_CFG) && bus_wdata[1];
  assign ack     = bus_wr && bus_addr == AW'(W_CTRL) && bus_wdata[0];

  always_comb begin
    first_id = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pend[i]) first_id = ID_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (srst_go) cnt <= CW'(RST_CYCLES);
    else if (busy) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '1;
    else if (srst_go || busy) mask <= '1;
    else if (bus_wr)
      for (int b = 0; b < NBANK; b++) begin
        if (bus_addr == AW'(W_MSET0 + b * W_STRIDE))
          mask[b*32 +: 32] <= mask[b*32 +: 32] | bus_wdata;
        if (bus_addr == AW'(W_MCLR0 + b * W_STRIDE))
          mask[b*32 +: 32] <= mask[b*32 +: 32] & ~bus_wdata;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_out   <= 1'b0;
      active_id <= '0;
    end else if (srst_go || busy) begin
      irq_out   <= 1'b0;
      active_id <= '0;
    end else if (irq_out) begin
      if (ack) irq_out <= 1'b0;
    end else if (any) begin
      irq_out   <= 1'b1;
      active_id <= first_id;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(W_REV))  bus_rdata = {24'd0, REVISION};
    if (bus_addr == AW'(W_CFG))  bus_rdata = {30'd0, busy, 1'b0};
    if (bus_addr == AW'(W_STAT)) bus_rdata = {31'd0, !busy};
    if (bus_addr == AW'(W_ACT))  bus_rdata = 32'(active_id);
    for (int b = 0; b < NBANK; b++) begin
      if (bus_addr == AW'(W_MCLR0 + b * W_STRIDE) || bus_addr == AW'(W_MSET0 + b * W_STRIDE))
        bus_rdata = mask[b*32 +: 32];
      if (bus_addr == AW'(W_PEND0 + b * W_STRIDE))
        bus_rdata = pend[b*32 +: 32];
    end
  end

  a_r6_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_out && any && !busy && !srst_go) |=> irq_out);
  a_r6_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_out && any && !busy && !srst_go) |=> active_id == $past(first_id));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !ack && !srst_go) |=> (irq_out && $stable(active_id)));
  a_r8_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && ack) |=> !irq_out);
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!irq_out && &mask));
  a_r9_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(RST_CYCLES));

endmodule

// File: tb/banked_irq_ctrl_test.sv
module banked_irq_ctrl_test;
  localparam int PERIOD = 10;
  localparam int NB = 3;
  localparam int N = NB * 32;
  localparam int RSTC = 6;
  localparam logic [7:0] REV = 8'h21;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] lines = '0;
  logic [7:0] addr = '0;
  logic wr = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  logic [6:0] aid;

  int compared = 0, mismatched = 0;
  string tag = "R1";

  logic [N-1:0] m_mask;
  bit m_act;
  int m_id, m_cnt;

  always #(PERIOD/2) clk = ~clk;

  banked_irq_ctrl #(.NBANK(NB), .RST_CYCLES(RSTC), .REVISION(REV), .AW(8)) uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq), .active_id(aid));

  function automatic logic [31:0] model_read(int off);
    int rel, b, k;
    if (off == 8'h00) return {24'd0, REV};
    if (off == 8'h10) return {30'd0, m_cnt != 0, 1'b0};
    if (off == 8'h14) return {31'd0, m_cnt == 0};
    if (off == 8'h40) return 32'(m_id);
    if (off >= 8'h88) begin
      rel = off - 8'h88; b = rel / 32; k = rel % 32;
      if (b < NB && (k == 0 || k == 4)) return m_mask[b*32 +: 32];
      if (b < NB && k == 16) return lines[b*32 +: 32] & ~m_mask[b*32 +: 32];
    end
    return 32'd0;
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(bit w, int off, logic [31:0] d);
    logic [N-1:0] pend;
    bit start, busy;
    int b, k, low;
    wr = w; addr = 8'(off / 4); wdata = d;
    #1;
    check("irq_out", 32'(irq), 32'(m_act));
    check("active_id", 32'(aid), 32'(m_id));
    check("rdata", rdata, model_read(off));
    pend = lines & ~m_mask;
    start = w && off == 8'h10 && d[1];
    busy = m_cnt != 0;
    low = -1;
    for (int i = N - 1; i >= 0; i--) if (pend[i]) low = i;
    if (start || busy) begin
      m_act = 0; m_id = 0;
    end else if (m_act) begin
      if (w && off == 8'h48 && d[0]) m_act = 0;
    end else if (low >= 0) begin
      m_act = 1; m_id = low;
    end
    if (start || busy) m_mask = '1;
    else if (w && off >= 8'h88) begin
      b = (off - 8'h88) / 32; k = (off - 8'h88) % 32;
      if (b < NB && k == 4) m_mask[b*32 +: 32] = m_mask[b*32 +: 32] | d;
      if (b < NB && k == 0) m_mask[b*32 +: 32] = m_mask[b*32 +: 32] & ~d;
    end
    if (start) m_cnt = RSTC; else if (m_cnt > 0) m_cnt--;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(int off); cyc(0, off, 0); endtask

  initial begin
    #(PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    m_mask = '1; m_act = 0; m_id = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, everything masked
    tag = "R1";
    lines = '1;
    rd(8'h14); rd(8'h8C); rd(8'hAC); rd(8'hCC); rd(8'h40);
    // R2: revision
    tag = "R2"; rd(8'h00);
    // R10: unmapped offsets
    tag = "R10";
    rd(8'h04); rd(8'h3C); rd(8'h90); rd(8'hEC);
    cyc(1, 8'h3C, 32'hFFFF_FFFF); cyc(1, 8'h94, 32'hFFFF_FFFF); rd(8'h88);
    // R4: unmask lines 37 and 39 in bank 1
    tag = "R4";
    lines = '0; lines[37] = 1; lines[39] = 1;
    cyc(1, 8'hA8, 32'h0000_00A0); rd(8'hA8);
    // R6: lowest pending line presented
    tag = "R6"; rd(8'h40); rd(8'hB8);
    // R7: held despite line drop and masking
    tag = "R7";
    lines[37] = 0; rd(8'h40);
    cyc(1, 8'hAC, 32'h0000_0080); rd(8'h40); rd(8'hAC);
    // R8: ack with bit 0 clear is ignored, then real ack
    tag = "R8";
    cyc(1, 8'h48, 32'h0000_0002); rd(8'h40);
    lines[37] = 1;
    cyc(1, 8'h48, 32'h0000_0001); rd(8'h40); rd(8'h40);
    cyc(1, 8'h48, 32'h0000_0001); rd(8'h40); cyc(1, 8'h48, 32'h1); rd(8'h40);
    // R3: set masks, other bits unchanged
    tag = "R3";
    cyc(1, 8'h8C, 32'h0); cyc(1, 8'h88, 32'h0000_0001); lines[0] = 1;
    rd(8'h40); cyc(1, 8'hAC, 32'h0000_0020); rd(8'hA8); rd(8'h88);
    // R5: pending readback across banks
    tag = "R5";
    cyc(1, 8'hC8, 32'h8000_0001); lines[95] = 1; lines[64] = 0;
    rd(8'hD8); rd(8'hB8); rd(8'h98);
    cyc(1, 8'h48, 32'h1); rd(8'h40); rd(8'h40);
    // R9: software reset
    tag = "R9";
    cyc(1, 8'h10, 32'h0000_0002);
    rd(8'h14); rd(8'h10); cyc(1, 8'hC8, 32'hFFFF_FFFF); cyc(1, 8'h48, 32'h1);
    rd(8'hC8); rd(8'h14); rd(8'h14); rd(8'h14); rd(8'h10); rd(8'hD8);
    // R6: random traffic against model
    tag = "R6";
    for (int t = 0; t < 2000; t++) begin
      int op, bk;
      lines = {$urandom & $urandom, $urandom & $urandom, $urandom & $urandom};
      op = $urandom % 16; bk = $urandom % 3;
      if (op < 3) cyc(1, 8'h88 + 32 * bk, $urandom & $urandom);
      else if (op < 5) cyc(1, 8'h8C + 32 * bk, $urandom & $urandom);
      else if (op < 9) cyc(1, 8'h48, 32'h1);
      else if (op == 9 && ($urandom % 8) == 0) cyc(1, 8'h10, 32'h2);
      else if (op < 12) rd(8'h98 + 32 * bk);
      else rd(8'h40);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule